// File: doc/BRIEF.md
# Bit-Banged PHY Management Register Slice

This block is a small memory-mapped register slice through which a processor drives a two-wire PHY management bus entirely in software. Firmware writes a control word that sets the bus clock level, the level to drive on the shared data line and whether that line is driven at all. It reads a status word to learn the level currently present on the data line. The slice provides three pad signals: the clock, the data-out level and a drive enable for an external open-drain data pad. It takes one input, the returned data line, and samples it through a synchronizer.

The bus only advances when software changes the clock level. Each control write whose clock bit differs from the level now held raises a one-cycle clock-edge event for the attached bus logic. A control write that leaves the clock bit as it is raises no event. The register window accepts only full 32-bit accesses. Byte and halfword accesses raise an access-error pulse and have no other effect.

Top module: `mgmt_bitbang_regs`

## Requirements
- R1: While reset is active and in the cycle after it, clock, data-out, drive enable, clock-edge event, access error and read data are all 0.
- R2: A word write to the control register (byte offset 0x28) loads control bit 0 into data-out only when control bit 1 is also 1 in that write; otherwise data-out keeps its value.
- R3: A word write to the control register loads control bit 2 into the clock output, visible one cycle after the write.
- R4: The clock-edge event is high for exactly the one cycle after a control word write whose bit 2 differs from the clock level held before it, and stays low for every other access.
- R5: A word write to the control register loads control bit 3 into the drive enable on every such write.
- R6: A word read of the status register (byte offset 0x2c) returns, one cycle later, the data line level in bit 0, taken after a synchronizer of SYNC_STAGES flops, with bits 31..1 zero.
- R7: An access with size code byte (00), halfword (01) or reserved (11) pulses the access error for one cycle, leaves all pad outputs unchanged, raises no clock-edge event and returns read data 0. Only size code 10 (word) is accepted.
- R8: Word reads of any offset other than the status register return 0, and word writes to any offset other than the control register leave all outputs unchanged. This includes offsets outside the 0x5c-byte window.
- R9: The control register is write-only: a word read of offset 0x28 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (7) | Byte address within the slice |
| req_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_rdata | output | DATA_W (32) | Read data, registered, valid the cycle after a read |
| access_err | output | 1 | One-cycle pulse after an access that is not a full word |
| mgmt_clk | output | 1 | Management bus clock level |
| mgmt_dout | output | 1 | Level to drive on the data pad |
| mgmt_doe | output | 1 | Data pad drive enable (0 releases the pad) |
| mgmt_din | input | 1 | Returned level of the shared data line |
| clk_edge | output | 1 | One-cycle event when a write changed the clock level |

## Verification
The bench repeats a control write with an unchanged clock bit. A design that compared against the written value instead of the held level would emit a spurious edge event or miss a real one. It writes data bit 0 with and without its enable bit, to catch a data-out that follows bit 0 unconditionally. Each output is checked after a byte write, a halfword read and a write to an unimplemented offset that carry the same control pattern, so a decoder that ignored the size or the offset would move the clock or pads. Status reads at both line levels expose a missing synchronizer or stray upper bits.

// File: rtl/mgmt_pkg.sv
// Shared constants and types for the management register slice.
// Assumes byte addressing with word registers at 4-byte aligned offsets.
package mgmt_pkg;

    // Byte offsets of the implemented registers
    localparam int CTRL_OFFSET = 'h28;
    localparam int STAT_OFFSET = 'h2c;
    localparam int WINDOW_BYTES = 'h5c;

    // Control register bit positions
    localparam int CB_DOUT  = 0;
    localparam int CB_DWEN  = 1;
    localparam int CB_CLK   = 2;
    localparam int CB_DOE   = 3;
    localparam int CB_COUNT = 4;

    // Access size codes
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

endpackage

// File: rtl/mgmt_sync.sv
// Multi-flop synchronizer for the returned management data line.
// Assumes STAGES >= 1; output lags the input by STAGES clock cycles.
module mgmt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            // Shift the line level through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mgmt_ctrl_reg.sv
// Holds the clock, data-out and drive-enable levels set by control writes,
// and raises a one-cycle edge event when a write changes the clock level.
// Assumes wr_i is already qualified as a full-word write to the control offset.
module mgmt_ctrl_reg
    import mgmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [CB_COUNT-1:0] bits_i,
    output logic                clk_o,
    output logic                dout_o,
    output logic                doe_o,
    output logic                edge_o
);

    logic clk_change;

    assign clk_change = wr_i && (bits_i[CB_CLK] != clk_o);

    // Clock level and drive enable follow every control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_o <= 1'b0;
            doe_o <= 1'b0;
        end else if (wr_i) begin
            clk_o <= bits_i[CB_CLK];
            doe_o <= bits_i[CB_DOE];
        end
    end

    // Data-out loads only when its enable bit accompanies the write
    always_ff @(posedge clk) begin
        if (!rst_n)                        dout_o <= 1'b0;
        else if (wr_i && bits_i[CB_DWEN])  dout_o <= bits_i[CB_DOUT];
    end

    // Edge event pulses once per clock level change
    always_ff @(posedge clk) begin
        if (!rst_n) edge_o <= 1'b0;
        else        edge_o <= clk_change;
    end

    // R4: an edge event always accompanies a changed clock level
    a_r4_edge_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (clk_o != $past(clk_o)));

    // R4: the clock never moves without an edge event
    a_r4_no_silent_move: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_o != $past(clk_o)) |-> edge_o);

    // R2: data-out holds unless an enabled control write occurred
    a_r2_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_i && bits_i[CB_DWEN]) |-> $stable(dout_o));

    // R3: the clock follows the written bit
    a_r3_clk_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_i) |-> (clk_o == $past(bits_i[CB_CLK])));

endmodule

// File: rtl/mgmt_rd_resp.sv
// Registers the read data and the access-error pulse for the slice.
// Assumes one request per cycle; status is the only readable register.
module mgmt_rd_resp
    import mgmt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              size_ok_i,
    input  logic              hit_stat_i,
    input  logic              line_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o
);

    logic bad_acc;
    logic rd_stat;

    assign bad_acc = req_valid_i && !size_ok_i;
    assign rd_stat = req_valid_i && size_ok_i && !req_write_i && hit_stat_i;

    // Read data: line level for a status read, zero for anything else
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= rd_stat ? DATA_W'(line_i) : '0;
    end

    // Error pulse for accesses narrower than a word
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= bad_acc;
    end

    // R7: an error pulse comes only from a rejected access
    a_r7_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(req_valid_i && !size_ok_i));

    // R7: a rejected access returns zero data
    a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (rdata_o == '0));

    // R6: upper read bits are always zero
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:1] == '0);

endmodule

// File: rtl/mgmt_bitbang_regs.sv
// Top of the bit-banged management register slice. Decodes full-word
// accesses to the control and status offsets and drives the pad signals.
// Assumes the data pad is open-drain: doe=0 releases the line.
module mgmt_bitbang_regs
    import mgmt_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              access_err,
    output logic              mgmt_clk,
    output logic              mgmt_dout,
    output logic              mgmt_doe,
    input  logic              mgmt_din,
    output logic              clk_edge
);

    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] CTRL_WA = WA_W'(CTRL_OFFSET / 4);
    localparam logic [WA_W-1:0] STAT_WA = WA_W'(STAT_OFFSET / 4);

    logic            size_ok;
    logic [WA_W-1:0] word_addr;
    logic            hit_ctrl;
    logic            hit_stat;
    logic            ctrl_wr;
    logic            line_sync;
    logic            unused_bits;

    assign size_ok     = (acc_size_e'(req_size) == SZ_WORD);
    assign word_addr   = req_addr[ADDR_W-1:2];
    assign hit_ctrl    = (word_addr == CTRL_WA);
    assign hit_stat    = (word_addr == STAT_WA);
    assign ctrl_wr     = req_valid && req_write && size_ok && hit_ctrl;
    assign unused_bits = ^{req_wdata[DATA_W-1:CB_COUNT], req_addr[1:0]};

    mgmt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (mgmt_din),
        .q_o   (line_sync)
    );

    mgmt_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (ctrl_wr),
        .bits_i (req_wdata[CB_COUNT-1:0]),
        .clk_o  (mgmt_clk),
        .dout_o (mgmt_dout),
        .doe_o  (mgmt_doe),
        .edge_o (clk_edge)
    );

    mgmt_rd_resp #(.DATA_W(DATA_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .size_ok_i   (size_ok),
        .hit_stat_i  (hit_stat),
        .line_i      (line_sync),
        .rdata_o     (rsp_rdata),
        .err_o       (access_err)
    );

    // R7: a rejected access leaves the pad outputs where they were
    a_r7_pads_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !size_ok) |->
            ($stable(mgmt_clk) && $stable(mgmt_dout) && $stable(mgmt_doe)));

    // R8: writes away from the control offset leave the pads alone
    a_r8_other_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && !hit_ctrl) |->
            ($stable(mgmt_clk) && $stable(mgmt_dout) && $stable(mgmt_doe)));

endmodule

// File: tb/sim_mgmt_bitbang_regs.sv
// Directed bench for the management register slice.
module sim_mgmt_bitbang_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        access_err;
    logic        mgmt_clk;
    logic        mgmt_dout;
    logic        mgmt_doe;
    logic        mgmt_din = 1'b0;
    logic        clk_edge;

    int checks = 0;
    int errors = 0;
    logic [31:0] got_rdata;
    logic        got_err;
    logic        got_edge;

    always #10 clk = ~clk;

    mgmt_bitbang_regs u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_wdata  (req_wdata),
        .rsp_rdata  (rsp_rdata),
        .access_err (access_err),
        .mgmt_clk   (mgmt_clk),
        .mgmt_dout  (mgmt_dout),
        .mgmt_doe   (mgmt_doe),
        .mgmt_din   (mgmt_din),
        .clk_edge   (clk_edge)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access; captures the registered response the cycle after it
    task automatic access(input logic wr, input logic [6:0] addr,
                          input logic [1:0] size, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_size  = size;
        req_wdata = data;
        @(negedge clk);
        got_rdata = rsp_rdata;
        got_err   = access_err;
        got_edge  = clk_edge;
        req_valid = 1'b0;
    endtask

    task automatic check_pads(input string req, input logic c, input logic d, input logic e);
        check(req, {29'd0, mgmt_clk, mgmt_dout, mgmt_doe}, {29'd0, c, d, e});
    endtask

    task automatic t_reset;
        check("R1 pads", {29'd0, mgmt_clk, mgmt_dout, mgmt_doe}, 32'd0);
        check("R1 edge/err", {30'd0, clk_edge, access_err}, 32'd0);
        check("R1 rdata", rsp_rdata, 32'd0);
    endtask

    task automatic t_clock;
        access(1'b1, 7'h28, 2'b10, 32'h4);
        check("R3 clk high", {31'd0, mgmt_clk}, 32'd1);
        check("R4 edge on rise", {31'd0, got_edge}, 32'd1);
        @(negedge clk);
        check("R4 edge one cycle", {31'd0, clk_edge}, 32'd0);
        access(1'b1, 7'h28, 2'b10, 32'h4);
        check("R4 no edge same level", {31'd0, got_edge}, 32'd0);
        check("R3 clk held", {31'd0, mgmt_clk}, 32'd1);
    endtask

    task automatic t_data;
        access(1'b1, 7'h28, 2'b10, 32'h1);
        check_pads("R2 dout ignored without enable", 1'b0, 1'b0, 1'b0);
        check("R4 edge on fall", {31'd0, got_edge}, 32'd1);
        access(1'b1, 7'h28, 2'b10, 32'h3);
        check_pads("R2 dout loaded", 1'b0, 1'b1, 1'b0);
        access(1'b1, 7'h28, 2'b10, 32'h8);
        check_pads("R5 doe set, R2 dout kept", 1'b0, 1'b1, 1'b1);
        access(1'b1, 7'h28, 2'b10, 32'h2);
        check_pads("R5 doe cleared, R2 dout zeroed", 1'b0, 1'b0, 1'b0);
        access(1'b1, 7'h28, 2'b10, 32'hB);
        check_pads("R2 R5 both set", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_status;
        mgmt_din = 1'b1;
        repeat (3) @(negedge clk);
        access(1'b0, 7'h2c, 2'b10, 32'h0);
        check("R6 status high", got_rdata, 32'h1);
        mgmt_din = 1'b0;
        repeat (3) @(negedge clk);
        access(1'b0, 7'h2c, 2'b10, 32'h0);
        check("R6 status low", got_rdata, 32'h0);
        check("R7 no err on word", {31'd0, got_err}, 32'd0);
        mgmt_din = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_size_err;
        access(1'b1, 7'h28, 2'b00, 32'h4);
        check("R7 byte write err", {31'd0, got_err}, 32'd1);
        check("R7 byte write no edge", {31'd0, got_edge}, 32'd0);
        check_pads("R7 byte write ignored", 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check("R7 err one cycle", {31'd0, access_err}, 32'd0);
        access(1'b0, 7'h2c, 2'b01, 32'h0);
        check("R7 half read err", {31'd0, got_err}, 32'd1);
        check("R7 half read data", got_rdata, 32'h0);
        access(1'b1, 7'h28, 2'b11, 32'h4);
        check("R7 reserved size err", {31'd0, got_err}, 32'd1);
        check_pads("R7 reserved write ignored", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_unmapped;
        access(1'b1, 7'h30, 2'b10, 32'h6);
        check_pads("R8 other offset write ignored", 1'b0, 1'b1, 1'b1);
        check("R8 no edge", {31'd0, got_edge}, 32'd0);
        access(1'b1, 7'h2c, 2'b10, 32'h4);
        check_pads("R8 status write ignored", 1'b0, 1'b1, 1'b1);
        access(1'b0, 7'h30, 2'b10, 32'h0);
        check("R8 other read zero", got_rdata, 32'h0);
        access(1'b0, 7'h60, 2'b10, 32'h0);
        check("R8 outside window zero", got_rdata, 32'h0);
        access(1'b0, 7'h28, 2'b10, 32'h0);
        check("R9 control reads zero", got_rdata, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clock();
        t_data();
        t_status();
        t_size_err();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule